// File: doc/BRIEF.md
# Ethernet Transmit Frame Check Sequence Stage

This block sits on the transmit path between the frame source and the MAC framing logic. It takes a byte-wide valid/ready stream of frame data and handles the 4-byte frame check sequence of each frame according to three flags. The flags are sampled with the first byte of the frame. A frame can get a freshly computed CRC-32 appended. It can be forwarded untouched because it already carries a good FCS. It can also have its trailing four bytes thrown away and replaced by a newly computed CRC-32.

Frames whose CRC the block computes are zero-padded up to a minimum data length before the CRC is taken, unless the frame asks for no padding. The output is again a byte-wide valid/ready stream. Its last marker sits on the final FCS byte, or on the final data byte for frames that are forwarded untouched. Backpressure from the output stalls the whole stage.

Top module: `fcs_inserter`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With in_no_crc=0 the output is the frame data followed by 4 FCS bytes. The FCS is the bit-reflected CRC-32 with polynomial 0x04C11DB7, initial value 0xFFFFFFFF and a final inversion, taken over the data, and it is sent least significant byte first. Over the ASCII string "123456789" it gives 0xCBF43926.
- R3: With in_no_crc=1 and in_replace=0 the output is exactly the input frame: same bytes, same length, no padding, and out_last on the final byte.
- R4: With in_no_crc=1 and in_replace=1 the last 4 input bytes are dropped and a CRC over the preceding bytes is sent in their place. If the frame has 4 bytes or fewer, all of its bytes are dropped.
- R5: With in_no_crc=0, in_replace has no effect and the frame is handled exactly as in R2.
- R6: With in_no_pad=0 in a CRC-computing mode, data shorter than 60 bytes is extended with zero bytes to 60 bytes before the CRC is computed, so the output is at least 64 bytes long.
- R7: With in_no_pad=1, no padding is added, and data of 60 bytes or more is never padded.
- R8: While out_valid=1 and out_ready=0, out_data and out_last hold. No byte is lost or duplicated under any pattern of out_ready.
- R9: The three mode flags are sampled only with the first byte of a frame. Their values on later bytes of the same frame have no effect.
- R10: After the last input byte of a CRC-computing frame is accepted, in_ready stays 0 while padding and FCS bytes are sent. The next frame is accepted once the FCS has been handed off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Stage can accept an input byte |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_no_crc | input | 1 | Frame flag: do not append a CRC |
| in_replace | input | 1 | Frame flag: overwrite the trailing 4 bytes with a CRC (only with in_no_crc) |
| in_no_pad | input | 1 | Frame flag: do not pad short frames |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Marks the final output byte of a frame |

## Verification
The assertions assume that every input frame ends with in_last, and that the source holds in_data, in_last and the flags steady while a byte waits for in_ready. They also assume that the flags on the first byte define the frame. The minimum-length assertion takes for granted that a padded frame was handed over whole, with no reset in the middle. The stimulus drives each frame as a contiguous burst that is held until accepted and always closes it with in_last. On every byte after the first it inverts all three flags, so a design that samples them late breaks the expected output. Output readiness runs either always high or from a pseudo-random pattern, so stalls land in data, padding and FCS phases.

// File: rtl/fcs_inserter.sv
module fcs_inserter #(
  parameter int MIN_DATA = 60,
  parameter int FCS_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_no_crc,
  input  logic       in_replace,
  input  logic       in_no_pad,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);
  localparam int CNT_W = $clog2(MIN_DATA + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_DATA);
  localparam int FILL_W = $clog2(FCS_LEN + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(FCS_LEN);
  localparam int IDX_W = $clog2(FCS_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_LEN - 1);
  localparam logic [31:0] POLY_R = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  typedef enum logic [1:0] {S_DATA, S_PAD, S_FCS} st_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ (((r[0] ^ b[i]) == 1'b1) ? POLY_R : 32'h0);
    return r;
  endfunction

  st_t               st;
  logic              sof;
  logic              m_nocrc, m_rep, m_nopad;
  logic [7:0]        dl [FCS_LEN];
  logic [FILL_W-1:0] fill;
  logic [31:0]       crc;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  fidx;

  logic f_nocrc, f_rep, f_nopad, mode_pass, mode_repl;
  logic out_free, acc;
  logic emit, e_last, upd;
  logic [7:0] e_data;
  logic [31:0] crc_nxt, crc_fin;
  logic [CNT_W-1:0] cnt_nxt;
  logic need_pad;

  assign f_nocrc   = sof ? in_no_crc  : m_nocrc;
  assign f_rep     = sof ? in_replace : m_rep;
  assign f_nopad   = sof ? in_no_pad  : m_nopad;
  assign mode_pass = f_nocrc && !f_rep;
  assign mode_repl = f_nocrc && f_rep;

  assign out_free = !out_valid || out_ready;
  assign in_ready = (st == S_DATA) && out_free;
  assign acc      = in_valid && in_ready;
  assign crc_fin  = ~crc;

  always_comb begin
    emit   = 1'b0;
    e_data = 8'h00;
    e_last = 1'b0;
    upd    = 1'b0;
    case (st)
      S_DATA: if (acc) begin
        if (mode_pass) begin
          emit   = 1'b1;
          e_data = in_data;
          e_last = in_last;
        end else if (mode_repl) begin
          if (fill == FILL_MAX) begin
            emit   = 1'b1;
            e_data = dl[FCS_LEN-1];
            upd    = 1'b1;
          end
        end else begin
          emit   = 1'b1;
          e_data = in_data;
          upd    = 1'b1;
        end
      end
      S_PAD: if (out_free) begin
        emit = 1'b1;
        upd  = 1'b1;
      end
      S_FCS: if (out_free) begin
        emit   = 1'b1;
        e_data = crc_fin[{fidx, 3'b000} +: 8];
        e_last = (fidx == IDX_LAST);
      end
      default: ;
    endcase
  end

  assign crc_nxt  = upd ? crc_step(crc, e_data) : crc;
  assign cnt_nxt  = (upd && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;
  assign need_pad = !f_nopad && (cnt_nxt != CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_DATA;
      sof       <= 1'b1;
      m_nocrc   <= 1'b0;
      m_rep     <= 1'b0;
      m_nopad   <= 1'b0;
      fill      <= '0;
      crc       <= CRC_INIT;
      cnt       <= '0;
      fidx      <= '0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_last  <= 1'b0;
      for (int i = 0; i < FCS_LEN; i++) dl[i] <= 8'h00;
    end else begin
      if (out_free) begin
        out_valid <= emit;
        out_data  <= e_data;
        out_last  <= e_last;
      end
      crc <= crc_nxt;
      cnt <= cnt_nxt;
      case (st)
        S_DATA: if (acc) begin
          sof <= in_last;
          if (sof) begin
            m_nocrc <= in_no_crc;
            m_rep   <= in_replace;
            m_nopad <= in_no_pad;
          end
          if (mode_repl) begin
            dl[0] <= in_data;
            for (int i = 1; i < FCS_LEN; i++) dl[i] <= dl[i-1];
            if (fill != FILL_MAX) fill <= fill + 1'b1;
          end
          if (in_last) begin
            fill <= '0;
            fidx <= '0;
            if (!mode_pass) st <= need_pad ? S_PAD : S_FCS;
          end
        end
        S_PAD: if (out_free && cnt_nxt == CNT_MAX) st <= S_FCS;
        S_FCS: if (out_free) begin
          fidx <= fidx + 1'b1;
          if (fidx == IDX_LAST) begin
            st  <= S_DATA;
            crc <= CRC_INIT;
            cnt <= '0;
          end
        end
        default: st <= S_DATA;
      endcase
    end
  end

  logic [15:0] ocnt;
  always_ff @(posedge clk) begin
    if (!rst_n) ocnt <= '0;
    else if (out_valid && out_ready) ocnt <= out_last ? 16'd0 : ocnt + 16'd1;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAD) && out_free |=> out_valid && out_data == 8'h00 && !out_last);
  // R6
  min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last && !(m_nocrc && !m_rep) && !m_nopad
    |-> (32'(ocnt) + 32'd1) >= 32'(MIN_DATA + FCS_LEN));
  // R10
  busy_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last && !mode_pass |=> !in_ready);
  // R3
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

// File: tb/sim_fcs_inserter.sv
`timescale 1ns/1ps
module sim_fcs_inserter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_no_crc = 1'b0, in_replace = 1'b0, in_no_pad = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  int errors = 0, checks = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  byte unsigned got [$];
  bit got_l [$];
  byte unsigned expq [$];
  byte unsigned fdat [$];

  always #2 clk = ~clk;

  fcs_inserter u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_no_crc(in_no_crc), .in_replace(in_replace),
    .in_no_pad(in_no_pad), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last));

  // {stall, no_pad, replace, no_crc, len[15:0]}
  localparam logic [19:0] VECS [13] = '{
    {4'b0100, 16'd64}, {4'b0000, 16'd20}, {4'b1100, 16'd20}, {4'b0001, 16'd30},
    {4'b1111, 16'd70}, {4'b0011, 16'd24}, {4'b0110, 16'd40}, {4'b1000, 16'd1},
    {4'b0111, 16'd5},  {4'b1111, 16'd4},  {4'b1001, 16'd1},  {4'b1000, 16'd59},
    {4'b0000, 16'd60}};

  function automatic logic [31:0] ref_crc(input byte unsigned q [$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (q[i]) begin
      c = c ^ {24'h0, q[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (lfsr[0] | lfsr[3]) : 1'b0;
  end

  always @(negedge clk) if (rst_n && out_valid && out_ready) begin
    got.push_back(out_data);
    got_l.push_back(out_last);
  end

  // flags are inverted on every byte after the first (R9)
  task automatic send(input bit nc, input bit rp, input bit np);
    foreach (fdat[i]) begin
      in_valid = 1'b1; in_data = fdat[i]; in_last = (i == fdat.size() - 1);
      in_no_crc = (i == 0) ? nc : !nc; in_replace = (i == 0) ? rp : !rp;
      in_no_pad = (i == 0) ? np : !np;
      forever begin @(negedge clk); if (in_ready) break; end
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic build(input int len, input int seed, input bit nc, input bit rp, input bit np);
    byte unsigned body [$];
    logic [31:0] c;
    fdat.delete(); expq.delete();
    for (int i = 0; i < len; i++) fdat.push_back(byte'((seed * 31 + i * 13 + 5) & 8'hff));
    if (nc && !rp) begin expq = fdat; return; end
    body = fdat;
    if (nc && rp) for (int i = 0; i < 4 && body.size() > 0; i++) void'(body.pop_back());
    if (!np) while (body.size() < 60) body.push_back(8'h00);
    c = ref_crc(body);
    expq = body;
    for (int i = 0; i < 4; i++) expq.push_back(byte'(c >> (8 * i)));
  endtask

  task automatic collect_and_compare(input string req);
    int mism = 0, lbad = 0, first_bad = -1;
    for (int t = 0; t < 3000 && got.size() < expq.size(); t++) @(negedge clk);
    repeat (6) @(negedge clk);
    check(got.size() == expq.size(), req, "length", got.size(), expq.size());
    foreach (expq[i]) if (i < got.size()) begin
      if (got[i] != expq[i]) begin mism++; if (first_bad < 0) first_bad = i; end
      if (got_l[i] != (i == expq.size() - 1)) lbad++;
    end
    check(mism == 0, req, "data mismatches (first index)", first_bad, -1);
    check(lbad == 0, req, "last marker errors", lbad, 0);
    got.delete(); got_l.delete();
  endtask

  task automatic run_frame(input int len, input int seed, input bit nc, input bit rp, input bit np, input string req);
    build(len, seed, nc, rp, np);
    send(nc, rp, np);
    collect_and_compare(req);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    byte unsigned kat [$];
    logic [7:0] held;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R2 known answer in bench model and in design
    kat = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    check(ref_crc(kat) == 32'hCBF43926, "R2", "reference CRC", ref_crc(kat), 32'hCBF43926);
    @(posedge clk); #1;
    fdat = kat;
    expq = kat;
    expq.push_back(8'h26); expq.push_back(8'h39); expq.push_back(8'hF4); expq.push_back(8'hCB);
    send(1'b0, 1'b0, 1'b1);
    collect_and_compare("R2");

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    foreach (VECS[v]) begin
      rdy_mode = VECS[v][19] ? 1 : 0;
      @(posedge clk); #1;
      run_frame(int'(VECS[v][15:0]), v + 1, VECS[v][16], VECS[v][17], VECS[v][18],
        VECS[v][16] ? (VECS[v][17] ? "R4" : "R3") : (VECS[v][17] ? "R5" : (VECS[v][18] ? "R7" : "R6")));
    end
    rdy_mode = 0;

    // R8 stall holds output and blocks input
    @(posedge clk); #1;
    rdy_mode = 2;
    build(3, 40, 1'b1, 1'b0, 1'b0);
    fork
      send(1'b1, 1'b0, 1'b0);
      begin
        repeat (3) @(negedge clk);
        held = out_data;
        check(out_valid == 1'b1, "R8", "valid under stall", out_valid, 1);
        repeat (5) @(negedge clk);
        check(out_valid == 1'b1 && out_data == held, "R8", "data held under stall", out_data, held);
        check(in_ready == 1'b0, "R8", "in_ready under stall", in_ready, 0);
        rdy_mode = 0;
      end
    join
    collect_and_compare("R8");

    // R10 input blocked during FCS
    @(posedge clk); #1;
    build(2, 41, 1'b0, 1'b0, 1'b1);
    send(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check(in_ready == 1'b0, "R10", "in_ready during FCS", in_ready, 0);
    collect_and_compare("R10");
    @(negedge clk);
    check(in_ready == 1'b1, "R10", "in_ready after FCS", in_ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule